// File: doc/BRIEF.md
# Saturating Narrowing Right-Shift Unit

This block turns a 128-bit vector of double-width lanes into half-width results. Each source lane is shifted right by an immediate. The block can round before the shift. It then either clamps the result to the destination range or keeps only its low bits. The narrowed results are packed into one 64-bit half of the destination vector. A separate scalar form works on element 0 alone.

All the arithmetic is combinational. One output register captures the new destination vector on each request, and a valid strobe follows one cycle later. A sticky flag records that some active lane was clamped, and it stays set until the clear input is raised. The surrounding pipeline supplies the operands and decides which destination register gets the result.

Top module: `narrow_shr_unit`

## Requirements
- R1: The size code selects the destination width DW: 0 gives 8, 1 gives 16, 2 gives 32. Code 3 is treated as 2. Source lane i occupies `src[i*2DW +: 2DW]`. In vector form there are 64/DW results, and result i lands at bit offset i*DW of the written half.
- R2: The effective shift is ((shift_imm - 1) mod DW) + 1. Immediates from 1 to DW are used unchanged. Any other value is folded into that range and does not stop the operation.
- R3: With `upper_half` = 0, the results fill bits 63:0 and bits 127:64 are zero. With `upper_half` = 1 in vector form, the results fill bits 127:64 and bits 63:0 are copied from `old_dst`.
- R4: With `round_en` = 1, the value 2^(shift-1) is added to the lane before the shift. The sum is kept wide enough that a carry out of a full-range lane is not lost.
- R5: `sat_mode` encodes the operation. 0 shifts logically and keeps the low DW bits, with no clamping. 1 takes a signed source and clamps it to the signed DW range. 2 takes a signed source and clamps it to [0, 2^DW-1]. 3 takes an unsigned source and clamps it to [0, 2^DW-1]. A signed source uses an arithmetic shift.
- R6: With `scalar_op` = 1, only element 0 is produced, in bits DW-1:0. Every other bit of the result is zero, whatever `upper_half` says.
- R7: `sat_sticky` becomes 1 the cycle after an accepted request in which an active lane clamped. It is cleared the cycle after `sat_clear` is raised, and a clear takes priority over a clamp in the same cycle. Lanes outside the scalar element never set it.
- R8: After reset, `result`, `out_valid` and `sat_sticky` are 0. `out_valid` is 1 exactly one cycle after `in_valid`. `result` holds its value while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe; the operands are sampled on this cycle |
| src | input | 128 | Source vector of double-width lanes |
| old_dst | input | 128 | Previous destination vector; supplies the kept low half |
| size_code | input | 2 | Destination element size code |
| shift_imm | input | 6 | Right-shift immediate |
| upper_half | input | 1 | Write the results into the upper 64 bits |
| scalar_op | input | 1 | Scalar form: element 0 only |
| round_en | input | 1 | Add the rounding constant before shifting |
| sat_mode | input | 2 | Truncate / signed-signed / signed-unsigned / unsigned-unsigned |
| sat_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | New destination vector |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Random full-width sources are run through all four modes and all three sizes, with rounding on and off. This tells the arithmetic shift apart from the logical one, and the signed clamp limits apart from the unsigned ones. Directed all-ones lanes with rounding at the maximum shift show whether the guard bit keeps the carry. Negative lanes in the signed-to-unsigned mode must clamp to zero. Folded immediates (0 and DW+1) check the shift masking. Upper-half writes use a distinct old destination, so a lost kept half is visible, and scalar requests use `upper_half` set to show that it is ignored. Clears issued together with clamping requests separate the priority of the sticky flag.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
   typedef enum logic [1:0] {
      NSR_TRUNC = 2'd0,
      NSR_SS    = 2'd1,
      NSR_SU    = 2'd2,
      NSR_UU    = 2'd3
   } nsr_mode_e;

   localparam int NSR_NUM_SIZES = 3;
   localparam int NSR_MIN_DW    = 8;
endpackage

// File: rtl/nsr_lane.sv
module nsr_lane #(
   parameter int DW  = 8,
   parameter int SHW = 6
) (
   input  logic [2*DW-1:0]      src_lane,
   input  logic [SHW-1:0]       shift_imm,
   input  logic                 round_en,
   input  nsr_pkg::nsr_mode_e   mode,
   output logic [DW-1:0]        res,
   output logic                 clamped
);
   localparam int SW  = 2 * DW;
   localparam int XW  = SW + 2;
   localparam int LGD = $clog2(DW);

   localparam logic signed [XW-1:0] S_MAX = {{(XW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [XW-1:0] S_MIN = {{(XW-DW+1){1'b1}}, {(DW-1){1'b0}}};
   localparam logic signed [XW-1:0] U_MAX = {{(XW-DW){1'b0}}, {DW{1'b1}}};
   localparam logic signed [XW-1:0] ZERO  = '0;

   if (SHW <= LGD) begin : g_bad_shw
      $error("nsr_lane: shift immediate too narrow for lane width");
   end

   logic [SHW-1:0]         sh_m1;
   logic [LGD:0]           sh_eff;
   logic                   signed_src;
   logic signed [XW-1:0]   ext;
   logic signed [XW-1:0]   rnd;
   logic signed [XW-1:0]   sum;
   logic signed [XW-1:0]   shr;

   always_comb begin
      sh_m1      = shift_imm - 1'b1;
      sh_eff     = {1'b0, sh_m1[LGD-1:0]} + 1'b1;
      signed_src = (mode == nsr_pkg::NSR_SS) || (mode == nsr_pkg::NSR_SU);
      ext        = $signed({{2{src_lane[SW-1] & signed_src}}, src_lane});
      rnd        = round_en ? $signed({{(XW-1){1'b0}}, 1'b1} << (sh_eff - 1'b1)) : ZERO;
      sum        = ext + rnd;
      shr        = sum >>> sh_eff;
   end

   always_comb begin
      res     = shr[DW-1:0];
      clamped = 1'b0;
      unique case (mode)
         nsr_pkg::NSR_TRUNC: begin
            res     = shr[DW-1:0];
            clamped = 1'b0;
         end
         nsr_pkg::NSR_SS: begin
            if (shr > S_MAX) begin
               res     = S_MAX[DW-1:0];
               clamped = 1'b1;
            end else if (shr < S_MIN) begin
               res     = S_MIN[DW-1:0];
               clamped = 1'b1;
            end
         end
         default: begin
            if (shr < ZERO) begin
               res     = '0;
               clamped = 1'b1;
            end else if (shr > U_MAX) begin
               res     = U_MAX[DW-1:0];
               clamped = 1'b1;
            end
         end
      endcase
   end

   always_comb begin
      if (mode == nsr_pkg::NSR_TRUNC)
         a_r5_trunc_no_clamp: assert (!clamped);
   end
endmodule

// File: rtl/nsr_size_bank.sv
module nsr_size_bank #(
   parameter int DW    = 8,
   parameter int VEC_W = 128,
   parameter int SHW   = 6
) (
   input  logic [VEC_W-1:0]     src,
   input  logic [SHW-1:0]       shift_imm,
   input  logic                 round_en,
   input  nsr_pkg::nsr_mode_e   mode,
   output logic [VEC_W/2-1:0]   half_res,
   output logic                 sat_any,
   output logic                 sat_first
);
   localparam int HALF_W = VEC_W / 2;
   localparam int NL     = HALF_W / DW;

   if (HALF_W % DW != 0) begin : g_bad_dw
      $error("nsr_size_bank: lane width must divide the half vector");
   end

   logic [NL-1:0] lane_sat;

   for (genvar i = 0; i < NL; i++) begin : g_lane
      nsr_lane #(.DW(DW), .SHW(SHW)) u_lane (
         .src_lane  (src[i*2*DW +: 2*DW]),
         .shift_imm (shift_imm),
         .round_en  (round_en),
         .mode      (mode),
         .res       (half_res[i*DW +: DW]),
         .clamped   (lane_sat[i])
      );
   end

   assign sat_any   = |lane_sat;
   assign sat_first = lane_sat[0];
endmodule

// File: rtl/nsr_pack.sv
module nsr_pack #(
   parameter int VEC_W = 128,
   parameter int SZW   = 2
) (
   input  logic [VEC_W/2-1:0]   half_res,
   input  logic [VEC_W-1:0]     old_dst,
   input  logic [SZW-1:0]       size_sel,
   input  logic                 upper_half,
   input  logic                 scalar_op,
   output logic [VEC_W-1:0]     packed_out
);
   localparam int HALF_W = VEC_W / 2;

   logic [HALF_W-1:0] elem_mask;

   always_comb begin
      elem_mask = (HALF_W'(1) << (nsr_pkg::NSR_MIN_DW << size_sel)) - 1'b1;
      if (scalar_op)
         packed_out = {{HALF_W{1'b0}}, half_res & elem_mask};
      else if (upper_half)
         packed_out = {half_res, old_dst[HALF_W-1:0]};
      else
         packed_out = {{HALF_W{1'b0}}, half_res};
   end
endmodule

// File: rtl/narrow_shr_unit.sv
module narrow_shr_unit #(
   parameter int VEC_W = 128,
   parameter int SHW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [VEC_W-1:0]  src,
   input  logic [VEC_W-1:0]  old_dst,
   input  logic [1:0]        size_code,
   input  logic [SHW-1:0]    shift_imm,
   input  logic              upper_half,
   input  logic              scalar_op,
   input  logic              round_en,
   input  logic [1:0]        sat_mode,
   input  logic              sat_clear,
   output logic              out_valid,
   output logic [VEC_W-1:0]  result,
   output logic              sat_sticky
);
   localparam int HALF_W = VEC_W / 2;
   localparam int NS     = nsr_pkg::NSR_NUM_SIZES;
   localparam int MAX_DW = nsr_pkg::NSR_MIN_DW << (NS - 1);

   if (HALF_W % MAX_DW != 0) begin : g_bad_vec
      $error("narrow_shr_unit: half vector must hold whole widest lanes");
   end

   nsr_pkg::nsr_mode_e mode;
   logic [1:0]         size_sel;
   logic [HALF_W-1:0]  bank_res [NS];
   logic [NS-1:0]      bank_any;
   logic [NS-1:0]      bank_first;
   logic [HALF_W-1:0]  half_sel;
   logic               hit;
   logic [VEC_W-1:0]   packed_out;

   assign mode     = nsr_pkg::nsr_mode_e'(sat_mode);
   assign size_sel = (size_code > 2'd2) ? 2'd2 : size_code;

   for (genvar g = 0; g < NS; g++) begin : g_size
      nsr_size_bank #(
         .DW    (nsr_pkg::NSR_MIN_DW << g),
         .VEC_W (VEC_W),
         .SHW   (SHW)
      ) u_bank (
         .src       (src),
         .shift_imm (shift_imm),
         .round_en  (round_en),
         .mode      (mode),
         .half_res  (bank_res[g]),
         .sat_any   (bank_any[g]),
         .sat_first (bank_first[g])
      );
   end

   always_comb begin
      half_sel = bank_res[size_sel];
      hit      = scalar_op ? bank_first[size_sel] : bank_any[size_sel];
   end

   nsr_pack #(.VEC_W(VEC_W), .SZW(2)) u_pack (
      .half_res   (half_sel),
      .old_dst    (old_dst),
      .size_sel   (size_sel),
      .upper_half (upper_half),
      .scalar_op  (scalar_op),
      .packed_out (packed_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         result     <= '0;
         sat_sticky <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            result <= packed_out;
         if (sat_clear)
            sat_sticky <= 1'b0;
         else if (in_valid && hit)
            sat_sticky <= 1'b1;
      end
   end

   // R8: strobe timing and hold
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   // R3: half placement
   a_r3_lower_write_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upper_half) |=> (result[VEC_W-1:HALF_W] == '0));
   a_r3_upper_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upper_half && !scalar_op) |=> (result[HALF_W-1:0] == $past(old_dst[HALF_W-1:0])));
   // R6: scalar leaves only element 0
   a_r6_scalar_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && scalar_op) |=> (result[VEC_W-1:MAX_DW] == '0));
   // R7: sticky flag behaviour
   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      sat_clear |=> !sat_sticky);
   a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_sticky && !sat_clear) |=> sat_sticky);
endmodule

// File: tb/tb_narrow_shr_unit.sv
module tb_narrow_shr_unit;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src = '0;
   logic [127:0] old_dst = '0;
   logic [1:0]   size_code = '0;
   logic [5:0]   shift_imm = 6'd1;
   logic         upper_half = 1'b0;
   logic         scalar_op = 1'b0;
   logic         round_en = 1'b0;
   logic [1:0]   sat_mode = '0;
   logic         sat_clear = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         sat_sticky;

   int n_checks = 0;
   int n_fail   = 0;
   bit exp_sticky = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   narrow_shr_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .old_dst(old_dst),
      .size_code(size_code), .shift_imm(shift_imm), .upper_half(upper_half),
      .scalar_op(scalar_op), .round_en(round_en), .sat_mode(sat_mode),
      .sat_clear(sat_clear), .out_valid(out_valid), .result(result),
      .sat_sticky(sat_sticky)
   );

   function automatic logic [127:0] ref_model(
      input logic [127:0] s, input logic [127:0] od, input logic [1:0] sz,
      input logic [5:0] imm, input bit up, input bit sc, input bit rn,
      input logic [1:0] md, output bit sat);
      int dw, nl, sh;
      logic [63:0] half;
      logic signed [69:0] x, lo, hi;
      logic [127:0] lane;
      logic [127:0] out;
      bit sgn;
      dw   = 8 << ((sz > 2) ? 2 : sz);
      nl   = sc ? 1 : 64 / dw;
      sh   = ((int'(imm) - 1 + 64) % dw) + 1;
      sgn  = (md == 2'd1) || (md == 2'd2);
      half = '0;
      sat  = 1'b0;
      for (int i = 0; i < nl; i++) begin
         lane = (s >> (i * 2 * dw)) & ((128'd1 << (2 * dw)) - 1);
         x = $signed({6'd0, lane[63:0]});
         if (sgn && lane[2*dw-1]) x = x - (70'sd1 <<< (2 * dw));
         if (rn) x = x + (70'sd1 <<< (sh - 1));
         x = x >>> sh;
         if (md == 2'd1) begin
            hi = (70'sd1 <<< (dw - 1)) - 1;
            lo = -(70'sd1 <<< (dw - 1));
         end else begin
            hi = (70'sd1 <<< dw) - 1;
            lo = 70'sd0;
         end
         if (md != 2'd0) begin
            if (x > hi) begin x = hi; sat = 1'b1; end
            else if (x < lo) begin x = lo; sat = 1'b1; end
         end
         half = half | ((64'(x) & ((64'd1 << dw) - 1)) << (i * dw));
      end
      if (sc)      out = {64'd0, half};
      else if (up) out = {half, od[63:0]};
      else         out = {64'd0, half};
      return out;
   endfunction

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [127:0] s, input logic [127:0] od,
                         input logic [1:0] sz, input logic [5:0] imm, input bit up,
                         input bit sc, input bit rn, input logic [1:0] md, input bit clr);
      logic [127:0] exp;
      bit sat;
      exp = ref_model(s, od, sz, imm, up, sc, rn, md, sat);
      @(negedge clk);
      src = s; old_dst = od; size_code = sz; shift_imm = imm; upper_half = up;
      scalar_op = sc; round_en = rn; sat_mode = md; sat_clear = clr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; sat_clear = 1'b0;
      exp_sticky = clr ? 1'b0 : (exp_sticky | sat);
      check(tag, result, exp);
      check({tag, " sticky R7"}, {127'd0, sat_sticky}, {127'd0, exp_sticky});
      check({tag, " strobe R8"}, {127'd0, out_valid}, 128'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
   end

   initial begin
      logic [127:0] hold;
      void'($urandom(32'd4242));
      #(CLK_PERIOD * 2 + 1);
      check("reset result R8", result, '0);
      check("reset flags R8", {126'd0, out_valid, sat_sticky}, '0);
      rst_n = 1'b1;

      // R1 / R5 truncating byte narrowing into the low half
      run_op("R1 trunc size0", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             {4{32'hA5A5_5A5A}}, 2'd0, 6'd4, 0, 0, 0, 2'd0, 0);
      // R3 upper half keeps old low half
      run_op("R3 upper write", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
             {4{32'hA5A5_5A5A}}, 2'd1, 6'd8, 1, 0, 0, 2'd0, 0);
      // R1 size code 3 acts as 2
      run_op("R1 size3 as 2", 128'h0000_0001_2345_6780_FFFF_FFFF_0000_0010,
             '0, 2'd3, 6'd4, 0, 0, 0, 2'd3, 0);
      // R4 carry out of full-range lane with guard bit
      run_op("R4 round carry", {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 2'd2, 6'd32, 0, 0, 1, 2'd3, 0);
      run_op("R4 round half", {8{16'h0018}}, '0, 2'd0, 6'd4, 0, 0, 1, 2'd0, 0);
      // R7 clear wins over a clamp in the same cycle
      run_op("R7 clear priority", {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 2'd2, 6'd32, 0, 0, 1, 2'd3, 1);
      // R5 negative signed into unsigned clamps to zero
      run_op("R5 neg to unsigned", {8{16'h8001}}, '0, 2'd0, 6'd1, 0, 0, 0, 2'd2, 0);
      run_op("R5 signed clamp", {4{32'h7FFF_0000, 32'h8000_0000}} , '0, 2'd1, 6'd1, 0, 0, 0, 2'd1, 1);
      // R2 folded immediates
      run_op("R2 imm zero", {8{16'hABCD}}, '0, 2'd0, 6'd0, 0, 0, 0, 2'd0, 0);
      run_op("R2 imm over", {8{16'hABCD}}, '0, 2'd0, 6'd9, 0, 0, 0, 2'd0, 0);
      // R6 scalar ignores upper_half; only lane 0 counts for saturation
      run_op("R6 scalar", {{7{16'h7FFF}}, 16'h0010}, {4{32'hFFFF_FFFF}}, 2'd0, 6'd1, 1, 1, 0, 2'd1, 1);
      run_op("R6 scalar sat", {2{64'h0000_0001_0000_0000}}, '0, 2'd2, 6'd1, 0, 1, 0, 2'd3, 1);

      // R8 hold while idle
      hold = result;
      @(negedge clk); @(negedge clk);
      check("R8 hold", result, hold);
      check("R8 idle strobe", {127'd0, out_valid}, '0);

      for (int k = 0; k < 400; k++) begin
         logic [1:0] sz, md;
         logic [5:0] imm;
         int dw;
         sz  = 2'($urandom_range(0, 3));
         md  = 2'($urandom_range(0, 3));
         dw  = 8 << ((sz > 2) ? 2 : sz);
         imm = ($urandom_range(0, 7) == 0) ? 6'($urandom_range(0, 63))
                                           : 6'($urandom_range(1, dw));
         run_op((md == 2'd0) ? "R5 rand trunc" : "R5 rand sat",
                {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                sz, imm, 1'($urandom), ($urandom_range(0, 5) == 0), 1'($urandom),
                md, ($urandom_range(0, 9) == 0));
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule